// File: doc/BRIEF.md
# Asymmetric Dual-Channel Address Mapper

This block sits in front of a two-channel memory controller. It turns each system byte address into a physical channel select and an address local to that channel. Software programs the capacity of two logical channels, A and B, in 64-byte lines. A swap bit ties logical A and B to physical channels 0 and 1, or the other way round.

With only one channel populated, the whole address space maps straight onto that channel. With both populated, the lowest part of the address space alternates line by line between the channels. This lower region is twice the size of channel B. Addresses above it fill the rest of channel A linearly. Addresses past the total capacity are flagged as out of range. A configuration in which B is larger than A is reported and every access is rejected. Results appear one clock after the request, together with a delayed copy of the request valid.

Top module: `dual_chan_addr_map`

## Requirements
- R1: While rst_ni is low, rsp_vld_o, rsp_sel_o, rsp_addr_o and rsp_oor_o are all zero.
- R2: rsp_vld_o equals req_vld_i from the previous clock. Every other response output describes that same request.
- R3: With capacity B zero and A nonzero, an in-range address selects logical A, and the local address equals the system address.
- R4: With capacity A zero and B nonzero, an in-range address selects logical B, and the local address equals the system address.
- R5: With both channels populated, a line index below twice capacity B lies in the interleaved zone. Address bit 6 at 0 selects A and at 1 selects B. The local address is the system address with bit 6 removed: bits above it shift down one, and bits 5:0 are kept.
- R6: With both channels populated, a line index from twice B up to A+B selects A. The local line index is the system line index minus capacity B, and the byte offset is kept.
- R7: A line index at or above A+B, including the case where both capacities are zero, sets rsp_oor_o and leaves rsp_sel_o at zero.
- R8: When both capacities are nonzero and B exceeds A, cfg_err_o is high (combinational from the configuration). Every request then answers with rsp_sel_o zero and rsp_oor_o zero.
- R9: The swap bit maps logical channels to physical channels. With cfg_swap_i = 0, A drives rsp_sel_o[0] and B drives rsp_sel_o[1]. With cfg_swap_i = 1 the mapping is reversed.
- R10: rsp_sel_o has at most one bit set. When rsp_vld_o is low, rsp_sel_o and rsp_oor_o are zero.
- R11: Whenever rsp_sel_o is zero, rsp_addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_cap_a_i | input | ADDR_W-6 | Logical channel A capacity in 64-byte lines |
| cfg_cap_b_i | input | ADDR_W-6 | Logical channel B capacity in 64-byte lines |
| cfg_swap_i | input | 1 | 0: A on physical 0, B on physical 1; 1: reversed |
| req_vld_i | input | 1 | Request address valid |
| req_addr_i | input | ADDR_W | System byte address |
| rsp_vld_o | output | 1 | Response valid, one cycle after request |
| rsp_sel_o | output | 2 | One-hot physical channel select |
| rsp_addr_o | output | ADDR_W | Channel-local byte address |
| rsp_oor_o | output | 1 | Address beyond total capacity |
| cfg_err_o | output | 1 | Capacity B exceeds capacity A |

## Verification
The hardest point to reach is the seam between the zones. Here the last interleaved line (an odd line that goes to B) sits next to the first linear line in A, and the local line index jumps from half the zone to capacity B. The vector table programs small capacities so that both sides of this seam, and the top line of the asymmetric zone, can be hit with a handful of addresses. It also reruns the seam with the swap bit set, and with equal capacities, where the linear zone is empty and the first address past the interleaved zone must be out of range.

// File: rtl/dcam_pkg.sv
package dcam_pkg;

   typedef enum logic [1:0] {
      Z_REJECT = 2'd0,
      Z_OOR    = 2'd1,
      Z_SYM    = 2'd2,
      Z_LINEAR = 2'd3
   } zone_e;

   typedef enum logic {
      LCH_A = 1'b0,
      LCH_B = 1'b1
   } lch_e;

endpackage

// File: rtl/dcam_zone_dec.sv
module dcam_zone_dec
   import dcam_pkg::*;
#(
   parameter int LINE_W = 26
) (
   input  logic [LINE_W-1:0] cap_a_i,
   input  logic [LINE_W-1:0] cap_b_i,
   input  logic [LINE_W-1:0] line_i,
   output zone_e             zone_o,
   output lch_e              lch_o,
   output logic              cfg_err_o
);

   localparam int EXT_W = LINE_W + 1;

   logic [EXT_W-1:0] total_lines;
   logic [EXT_W-1:0] sym_top;
   logic [EXT_W-1:0] line_ext;
   logic             a_empty;
   logic             b_empty;

   assign a_empty     = (cap_a_i == '0);
   assign b_empty     = (cap_b_i == '0);
   assign total_lines = {1'b0, cap_a_i} + {1'b0, cap_b_i};
   assign sym_top     = {cap_b_i, 1'b0};
   assign line_ext    = {1'b0, line_i};
   assign cfg_err_o   = !a_empty && !b_empty && (cap_b_i > cap_a_i);

   always_comb begin
      zone_o = Z_OOR;
      lch_o  = LCH_A;
      if (cfg_err_o) begin
         zone_o = Z_REJECT;
      end else if (line_ext >= total_lines) begin
         zone_o = Z_OOR;
      end else if (b_empty) begin
         zone_o = Z_LINEAR;
         lch_o  = LCH_A;
      end else if (a_empty) begin
         zone_o = Z_LINEAR;
         lch_o  = LCH_B;
      end else if (line_ext < sym_top) begin
         zone_o = Z_SYM;
         lch_o  = line_i[0] ? LCH_B : LCH_A;
      end else begin
         zone_o = Z_LINEAR;
         lch_o  = LCH_A;
      end
   end

endmodule

// File: rtl/dcam_local_calc.sv
module dcam_local_calc
   import dcam_pkg::*;
#(
   parameter int LINE_W = 26
) (
   input  zone_e             zone_i,
   input  lch_e              lch_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic [LINE_W-1:0] cap_b_i,
   output logic [LINE_W-1:0] local_line_o
);

   logic [LINE_W-1:0] halved;
   logic [LINE_W-1:0] shifted;

   assign halved  = {1'b0, line_i[LINE_W-1:1]};
   assign shifted = (lch_i == LCH_A) ? (line_i - cap_b_i) : line_i;

   always_comb begin
      unique case (zone_i)
         Z_SYM:    local_line_o = halved;
         Z_LINEAR: local_line_o = shifted;
         default:  local_line_o = '0;
      endcase
   end

endmodule

// File: rtl/dcam_phys_sel.sv
module dcam_phys_sel
   import dcam_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              hit_i,
   input  lch_e              lch_i,
   input  logic              swap_i,
   output logic [NUM_CH-1:0] sel_o
);

   logic phys_idx;

   assign phys_idx = (lch_i == LCH_B) ^ swap_i;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic G_IDX = (g == 1);
      assign sel_o[g] = hit_i && (phys_idx == G_IDX);
   end

endmodule

// File: rtl/dual_chan_addr_map.sv
module dual_chan_addr_map
   import dcam_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LINE_LG = 6
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [ADDR_W-LINE_LG-1:0]  cfg_cap_a_i,
   input  logic [ADDR_W-LINE_LG-1:0]  cfg_cap_b_i,
   input  logic                       cfg_swap_i,
   input  logic                       req_vld_i,
   input  logic [ADDR_W-1:0]          req_addr_i,
   output logic                       rsp_vld_o,
   output logic [1:0]                 rsp_sel_o,
   output logic [ADDR_W-1:0]          rsp_addr_o,
   output logic                       rsp_oor_o,
   output logic                       cfg_err_o
);

   localparam int LINE_W = ADDR_W - LINE_LG;
   localparam int NUM_CH = 2;

   if (LINE_LG < 1) begin : g_bad_line
      $error("LINE_LG must be at least 1");
   end
   if (LINE_W < 2) begin : g_bad_addr
      $error("ADDR_W must exceed LINE_LG by at least 2");
   end

   logic [LINE_W-1:0]  line;
   logic [LINE_LG-1:0] offset;
   zone_e              zone;
   lch_e               lch;
   logic [LINE_W-1:0]  local_line;
   logic               hit;
   logic [NUM_CH-1:0]  sel;

   assign line   = req_addr_i[ADDR_W-1:LINE_LG];
   assign offset = req_addr_i[LINE_LG-1:0];
   assign hit    = (zone == Z_SYM) || (zone == Z_LINEAR);

   dcam_zone_dec #(.LINE_W(LINE_W)) u_zone (
      .cap_a_i   (cfg_cap_a_i),
      .cap_b_i   (cfg_cap_b_i),
      .line_i    (line),
      .zone_o    (zone),
      .lch_o     (lch),
      .cfg_err_o (cfg_err_o)
   );

   dcam_local_calc #(.LINE_W(LINE_W)) u_local (
      .zone_i       (zone),
      .lch_i        (lch),
      .line_i       (line),
      .cap_b_i      (cfg_cap_b_i),
      .local_line_o (local_line)
   );

   dcam_phys_sel #(.NUM_CH(NUM_CH)) u_sel (
      .hit_i  (hit),
      .lch_i  (lch),
      .swap_i (cfg_swap_i),
      .sel_o  (sel)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rsp_vld_o  <= 1'b0;
         rsp_sel_o  <= '0;
         rsp_addr_o <= '0;
         rsp_oor_o  <= 1'b0;
      end else begin
         rsp_vld_o  <= req_vld_i;
         rsp_sel_o  <= req_vld_i ? sel : '0;
         rsp_addr_o <= (req_vld_i && hit) ? {local_line, offset} : '0;
         rsp_oor_o  <= req_vld_i && (zone == Z_OOR);
      end
   end

   AST_VLD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_vld_i |=> rsp_vld_o); // R2
   AST_VLD_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_vld_i |=> !rsp_vld_o); // R2
   AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(rsp_sel_o)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rsp_vld_o |-> (rsp_sel_o == '0 && !rsp_oor_o)); // R10
   AST_OOR_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_oor_o |-> (rsp_sel_o == '0)); // R7
   AST_CFG_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_vld_i && cfg_err_o) |=> (rsp_sel_o == '0 && !rsp_oor_o)); // R8
   AST_NOSEL_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_sel_o == '0) |-> (rsp_addr_o == '0)); // R11

endmodule

// File: tb/dual_chan_addr_map_tb.sv
`timescale 1ns/1ps
module dual_chan_addr_map_tb;

   typedef struct packed {
      logic [25:0] ca;
      logic [25:0] cb;
      logic        sw;
      logic [31:0] addr;
      logic [1:0]  sel;
      logic [31:0] la;
      logic        oor;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{26'd16, 26'd8, 1'b0, 32'h000, 2'b01, 32'h000, 1'b0, 8'd5},  // R5 line 0 to A
      '{26'd16, 26'd8, 1'b0, 32'h045, 2'b10, 32'h005, 1'b0, 8'd5},  // R5 odd line to B
      '{26'd16, 26'd8, 1'b0, 32'h3FF, 2'b10, 32'h1FF, 1'b0, 8'd5},  // R5 last sym line
      '{26'd16, 26'd8, 1'b0, 32'h380, 2'b01, 32'h1C0, 1'b0, 8'd5},  // R5
      '{26'd16, 26'd8, 1'b0, 32'h400, 2'b01, 32'h200, 1'b0, 8'd6},  // R6 first linear line
      '{26'd16, 26'd8, 1'b0, 32'h5FF, 2'b01, 32'h3FF, 1'b0, 8'd6},  // R6 top byte
      '{26'd16, 26'd8, 1'b0, 32'h600, 2'b00, 32'h000, 1'b1, 8'd7},  // R7 just past total
      '{26'd16, 26'd8, 1'b1, 32'h045, 2'b01, 32'h005, 1'b0, 8'd9},  // R9 B on phys 0
      '{26'd16, 26'd8, 1'b1, 32'h400, 2'b10, 32'h200, 1'b0, 8'd9},  // R9 A on phys 1
      '{26'd10, 26'd0, 1'b0, 32'h27F, 2'b01, 32'h27F, 1'b0, 8'd3},  // R3 A only
      '{26'd10, 26'd0, 1'b0, 32'h280, 2'b00, 32'h000, 1'b1, 8'd7},  // R7 A only past top
      '{26'd0,  26'd5, 1'b0, 32'h100, 2'b10, 32'h100, 1'b0, 8'd4},  // R4 B only
      '{26'd0,  26'd5, 1'b0, 32'h140, 2'b00, 32'h000, 1'b1, 8'd7},  // R7 B only past top
      '{26'd4,  26'd6, 1'b0, 32'h000, 2'b00, 32'h000, 1'b0, 8'd8},  // R8 rejected
      '{26'd0,  26'd0, 1'b0, 32'h000, 2'b00, 32'h000, 1'b1, 8'd7},  // R7 nothing populated
      '{26'd4,  26'd4, 1'b0, 32'h1C0, 2'b10, 32'h0C0, 1'b0, 8'd5},  // R5 equal sizes
      '{26'd4,  26'd4, 1'b0, 32'h200, 2'b00, 32'h000, 1'b1, 8'd7}   // R7 equal sizes
   };

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [25:0] cfg_cap_a_i = '0;
   logic [25:0] cfg_cap_b_i = '0;
   logic        cfg_swap_i = 1'b0;
   logic        req_vld_i = 1'b0;
   logic [31:0] req_addr_i = '0;
   logic        rsp_vld_o;
   logic [1:0]  rsp_sel_o;
   logic [31:0] rsp_addr_o;
   logic        rsp_oor_o;
   logic        cfg_err_o;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #10 clk_i = ~clk_i;

   dual_chan_addr_map u_dut (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_cap_a_i (cfg_cap_a_i),
      .cfg_cap_b_i (cfg_cap_b_i),
      .cfg_swap_i  (cfg_swap_i),
      .req_vld_i   (req_vld_i),
      .req_addr_i  (req_addr_i),
      .rsp_vld_o   (rsp_vld_o),
      .rsp_sel_o   (rsp_sel_o),
      .rsp_addr_o  (rsp_addr_o),
      .rsp_oor_o   (rsp_oor_o),
      .cfg_err_o   (cfg_err_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      // R1: outputs quiet in reset even with a request present
      req_vld_i = 1'b1;
      cfg_cap_a_i = 26'd16;
      @(negedge clk_i);
      check("R1", {61'd0, rsp_vld_o, rsp_oor_o, 1'b0}, 64'd0);
      check("R1", {30'd0, rsp_sel_o, rsp_addr_o}, 64'd0);
      req_vld_i = 1'b0;
      rst_ni = 1'b1;
      @(negedge clk_i);

      for (int i = 0; i < NV; i++) begin
         cfg_cap_a_i = VECS[i].ca;
         cfg_cap_b_i = VECS[i].cb;
         cfg_swap_i  = VECS[i].sw;
         req_addr_i  = VECS[i].addr;
         req_vld_i   = 1'b1;
         @(negedge clk_i);
         if (rsp_sel_o !== VECS[i].sel || rsp_addr_o !== VECS[i].la ||
             rsp_oor_o !== VECS[i].oor || rsp_vld_o !== 1'b1) begin
            errors++;
            $display("FAIL R%0d vec %0d: actual sel=%b addr=%0h oor=%b vld=%b expected sel=%b addr=%0h oor=%b vld=1",
                     VECS[i].rq, i, rsp_sel_o, rsp_addr_o, rsp_oor_o, rsp_vld_o,
                     VECS[i].sel, VECS[i].la, VECS[i].oor);
         end
         checks++;
      end

      // R8: configuration error flag, combinational
      cfg_cap_a_i = 26'd4; cfg_cap_b_i = 26'd6;
      #1 check("R8", {63'd0, cfg_err_o}, 64'd1);
      cfg_cap_a_i = 26'd6;
      #1 check("R8", {63'd0, cfg_err_o}, 64'd0);
      cfg_cap_a_i = 26'd0;
      #1 check("R8", {63'd0, cfg_err_o}, 64'd0);

      // R2 / R10: valid drops one cycle after request drops, outputs quiet
      cfg_cap_a_i = 26'd16; cfg_cap_b_i = 26'd8; cfg_swap_i = 1'b0;
      req_addr_i = 32'h045;
      req_vld_i = 1'b1;
      @(negedge clk_i);
      req_vld_i = 1'b0;
      check("R2", {63'd0, rsp_vld_o}, 64'd1);
      @(negedge clk_i);
      check("R2", {63'd0, rsp_vld_o}, 64'd0);
      check("R10", {61'd0, rsp_sel_o, rsp_oor_o}, 64'd0);
      check("R11", {32'd0, rsp_addr_o}, 64'd0);

      // R2: result belongs to the previous request on back-to-back changes
      req_vld_i = 1'b1;
      req_addr_i = 32'h400;
      @(negedge clk_i);
      req_addr_i = 32'h040;
      check("R2", {30'd0, rsp_sel_o, rsp_addr_o}, {30'd0, 2'b01, 32'h200});
      @(negedge clk_i);
      req_vld_i = 1'b0;
      check("R2", {30'd0, rsp_sel_o, rsp_addr_o}, {30'd0, 2'b10, 32'h000});

      // R1: reset asserted mid-run clears outputs
      req_vld_i = 1'b1;
      rst_ni = 1'b0;
      @(negedge clk_i);
      check("R1", {29'd0, rsp_vld_o, rsp_sel_o, rsp_addr_o}, 64'd0);
      rst_ni = 1'b1;
      req_vld_i = 1'b0;
      @(negedge clk_i);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule